// File: doc/BRIEF.md
# Paged memory address translator

This block sits between a 16-bit CPU bus and a wider global memory space. It holds two small control registers on a simple register bus. The first is a 4-bit page index. It chooses which 16 KB block of a 256 KB flash space appears in the local window at 0x8000–0xBFFF. The second is an 8-bit direct-page register. It supplies the high byte of the local address for short direct-mode accesses, in which the CPU gives only an 8-bit offset.

Each cycle the block takes either a full 16-bit local address or a direct-mode offset. It forms the local address and maps it to a global address. It also reports which region the access falls in: paged flash, direct, or plain. The core can overwrite the page index through a separate load port, which it uses when it changes pages on subroutine call and return. The direct-page register accepts only its first write after reset.

Top module: `page_xlate`

## Requirements
- R1: After reset the page index reads 0x0E (bits 3..1 set, bit 0 clear) and the direct-page register reads 0x00.
- R2: The page index sits at register offset 0x31. A bus write there loads wdata[3:0]. A read there returns {4'b0000, index}. It can be read and written at any time.
- R3: The direct-page register sits at register offset 0x30. The first bus write to it after reset loads all 8 bits of wdata.
- R4: Once the direct-page register has been written, later writes to offset 0x30 leave it unchanged until the next reset. Reads return the latched value. A reset clears the register and allows one new write.
- R5: When core_ld is high, core_pidx is loaded into the page index at the clock edge.
- R6: If core_ld is high in the same cycle as a bus write to offset 0x31, the page index takes core_pidx.
- R7: A local address in 0x8000–0xBFFF (bits 15:14 = 2'b10) maps to global address {index, addr[13:0]}, and region reads 2'b10 (flash).
- R8: When acc_direct is high, the local address is {direct-page, acc_ofs}. If that address lies outside the window, region reads 2'b01 (direct) and the global address is {2'b00, local}. If it lies inside the window, R7 applies.
- R9: A non-direct local address outside the window passes through as {2'b00, addr}, and region reads 2'b00 (plain).
- R10: Translation is combinational from the register values. A register write made in one cycle changes the translation of accesses from the next cycle on.
- R11: Reads of any offset other than 0x30 and 0x31 return 0x00. Writes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rb_wr | input | 1 | Register bus write strobe |
| rb_addr | input | 8 | Register bus offset |
| rb_wdata | input | 8 | Register bus write data |
| rb_rdata | output | 8 | Register bus read data (combinational) |
| core_ld | input | 1 | Core-side page index load strobe |
| core_pidx | input | 4 | Core-side page index value |
| acc_direct | input | 1 | 1: direct-mode access using acc_ofs |
| acc_addr | input | 16 | Local address for non-direct access |
| acc_ofs | input | 8 | Direct-mode 8-bit offset |
| loc_addr | output | 16 | Formed local address |
| glb_addr | output | 18 | Global address |
| region | output | 2 | 00 plain, 01 direct, 10 paged flash |

## Verification
Two functions can fall in the same cycle. A core-side page load can coincide with a bus write to the page index. A direct-mode access can form an address inside the paged window, so the direct and flash regions overlap. The bench provokes both with random stimulus: each cycle it drives random strobes, random offsets and random direct-page values. It also adds directed cases. These set the direct page to 0x80–0xBF and fire both page writers in one cycle. It then checks that the page index takes the core value and that flash mapping wins over direct.

// File: rtl/pgx_pkg.sv
// Package: shared types for the paged address translator.
// Assumes two-bit region codes that downstream decoders read directly.
package pgx_pkg;
    typedef enum logic [1:0] {
        RGN_PLAIN  = 2'b00,
        RGN_DIRECT = 2'b01,
        RGN_FLASH  = 2'b10
    } rgn_e;
endpackage

// File: rtl/pgx_page_reg.sv
// Page index register. It is loaded from the register bus or from a core-side
// port, and the core port wins a collision.
// Assumes both strobes are synchronous to clk; reset is synchronous active-low.
module pgx_page_reg #(
    parameter int PIDX_W = 4,
    parameter logic [PIDX_W-1:0] RST_VAL = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [PIDX_W-1:0] bus_d,
    input  logic              core_we,
    input  logic [PIDX_W-1:0] core_d,
    output logic [PIDX_W-1:0] q
);
    // Hold the index; the core load takes priority over the bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (core_we)
            q <= core_d;
        else if (bus_we)
            q <= bus_d;
    end
endmodule

// File: rtl/pgx_dpage_reg.sv
// Direct-page register. It accepts one write after reset and ignores the rest.
// Assumes software writes it once; later writes are silently dropped.
module pgx_dpage_reg #(
    parameter int DP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [DP_W-1:0] bus_d,
    output logic [DP_W-1:0] q,
    output logic            locked
);
    // Latch the first write and set the lock with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            locked <= 1'b0;
        end else if (bus_we && !locked) begin
            q      <= bus_d;
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/pgx_addr_map.sv
// Combinational translator. It forms the local address, classifies it and
// builds the global address.
// Assumes the window is the quarter of local space whose top two bits match
// WIN_TAG, and that the global width is at least the local width.
module pgx_addr_map
    import pgx_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PIDX_W  = 4,
    parameter int DP_W    = 8,
    parameter logic [1:0] WIN_TAG = 2'b10,
    localparam int OFS_W   = LADDR_W - DP_W,
    localparam int BLK_W   = LADDR_W - 2,
    localparam int GADDR_W = PIDX_W + BLK_W
) (
    input  logic               acc_direct,
    input  logic [LADDR_W-1:0] acc_addr,
    input  logic [OFS_W-1:0]   acc_ofs,
    input  logic [PIDX_W-1:0]  pidx,
    input  logic [DP_W-1:0]    dpage,
    output logic [LADDR_W-1:0] loc_addr,
    output logic [GADDR_W-1:0] glb_addr,
    output rgn_e               region
);
    logic               in_win;
    logic [GADDR_W-1:0] pass_addr;

    // Pick the local address source: the direct page plus offset, or the full address.
    always_comb begin
        loc_addr = acc_direct ? {dpage, acc_ofs} : acc_addr;
    end

    // Test whether the local address falls in the paged window.
    always_comb begin
        in_win = (loc_addr[LADDR_W-1 -: 2] == WIN_TAG);
    end

    // Widen the local address for pass-through, zero-extending when the global space is wider.
    generate
        if (GADDR_W > LADDR_W) begin : g_widen
            assign pass_addr = {{(GADDR_W-LADDR_W){1'b0}}, loc_addr};
        end else begin : g_same
            assign pass_addr = loc_addr[GADDR_W-1:0];
        end
    endgenerate

    // Choose the global address and region; the flash window takes priority.
    always_comb begin
        if (in_win) begin
            glb_addr = {pidx, loc_addr[BLK_W-1:0]};
            region   = RGN_FLASH;
        end else begin
            glb_addr = pass_addr;
            region   = acc_direct ? RGN_DIRECT : RGN_PLAIN;
        end
    end
endmodule

// File: rtl/page_xlate.sv
// Top of the paged address translator. It decodes register bus writes,
// muxes read data and instantiates the two registers and the mapper.
// Assumes a single-cycle register bus with combinational read data.
module page_xlate
    import pgx_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PIDX_W  = 4,
    parameter int DP_W    = 8,
    parameter int RB_AW   = 8,
    parameter int RB_DW   = 8,
    parameter logic [RB_AW-1:0] DP_OFS   = 8'h30,
    parameter logic [RB_AW-1:0] PIDX_OFS = 8'h31,
    parameter logic [PIDX_W-1:0] PIDX_RST = 4'hE,
    localparam int OFS_W   = LADDR_W - DP_W,
    localparam int GADDR_W = PIDX_W + LADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rb_wr,
    input  logic [RB_AW-1:0]   rb_addr,
    input  logic [RB_DW-1:0]   rb_wdata,
    output logic [RB_DW-1:0]   rb_rdata,
    input  logic               core_ld,
    input  logic [PIDX_W-1:0]  core_pidx,
    input  logic               acc_direct,
    input  logic [LADDR_W-1:0] acc_addr,
    input  logic [OFS_W-1:0]   acc_ofs,
    output logic [LADDR_W-1:0] loc_addr,
    output logic [GADDR_W-1:0] glb_addr,
    output logic [1:0]         region
);
    logic              we_pidx;
    logic              we_dp;
    logic [PIDX_W-1:0] pidx_q;
    logic [DP_W-1:0]   dp_q;
    logic              dp_lock;
    rgn_e              rgn;

    // Decode which register a bus write targets.
    always_comb begin
        we_pidx = rb_wr && (rb_addr == PIDX_OFS);
        we_dp   = rb_wr && (rb_addr == DP_OFS);
    end

    pgx_page_reg #(.PIDX_W(PIDX_W), .RST_VAL(PIDX_RST)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_we  (we_pidx),
        .bus_d   (rb_wdata[PIDX_W-1:0]),
        .core_we (core_ld),
        .core_d  (core_pidx),
        .q       (pidx_q)
    );

    pgx_dpage_reg #(.DP_W(DP_W)) u_dpage (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_we (we_dp),
        .bus_d  (rb_wdata[DP_W-1:0]),
        .q      (dp_q),
        .locked (dp_lock)
    );

    pgx_addr_map #(.LADDR_W(LADDR_W), .PIDX_W(PIDX_W), .DP_W(DP_W)) u_map (
        .acc_direct (acc_direct),
        .acc_addr   (acc_addr),
        .acc_ofs    (acc_ofs),
        .pidx       (pidx_q),
        .dpage      (dp_q),
        .loc_addr   (loc_addr),
        .glb_addr   (glb_addr),
        .region     (rgn)
    );

    // Drive the region code on the output port.
    always_comb begin
        region = rgn;
    end

    // Mux read data, zero-extended; unmapped offsets read zero.
    always_comb begin
        rb_rdata = '0;
        if (rb_addr == PIDX_OFS)
            rb_rdata[PIDX_W-1:0] = pidx_q;
        else if (rb_addr == DP_OFS)
            rb_rdata[DP_W-1:0] = dp_q;
    end
endmodule

// File: rtl/page_xlate_chk.sv
// Checker for page_xlate. It relates bus and core strobes to register
// state and region outputs over time. It is bound to every page_xlate instance.
module page_xlate_chk #(
    parameter int LADDR_W = 16,
    parameter int PIDX_W  = 4,
    parameter int DP_W    = 8,
    parameter int RB_AW   = 8,
    parameter int RB_DW   = 8,
    parameter int GADDR_W = 18,
    parameter logic [RB_AW-1:0] DP_OFS   = 8'h30,
    parameter logic [RB_AW-1:0] PIDX_OFS = 8'h31
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rb_wr,
    input logic [RB_AW-1:0]   rb_addr,
    input logic [RB_DW-1:0]   rb_wdata,
    input logic [RB_DW-1:0]   rb_rdata,
    input logic               core_ld,
    input logic [PIDX_W-1:0]  core_pidx,
    input logic               acc_direct,
    input logic [LADDR_W-1:0] loc_addr,
    input logic [GADDR_W-1:0] glb_addr,
    input logic [1:0]         region,
    input logic [PIDX_W-1:0]  pidx_q,
    input logic [DP_W-1:0]    dp_q,
    input logic               dp_lock
);
    // R5
    core_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ld |=> pidx_q == $past(core_pidx));

    // R2
    bus_pidx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_wr && rb_addr == PIDX_OFS && !core_ld) |=> pidx_q == $past(rb_wdata[PIDX_W-1:0]));

    // R4
    dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_lock |=> $stable(dp_q));

    // R3
    dp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_wr && rb_addr == DP_OFS && !dp_lock) |=> dp_q == $past(rb_wdata[DP_W-1:0]));

    // R7
    win_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr[LADDR_W-1 -: 2] == 2'b10) |-> region == 2'b10);

    // R9
    plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 2'b00) |-> (glb_addr[LADDR_W-1:0] == loc_addr && !acc_direct));

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_addr != DP_OFS && rb_addr != PIDX_OFS) |-> rb_rdata == '0);
endmodule

bind page_xlate page_xlate_chk #(
    .LADDR_W(LADDR_W), .PIDX_W(PIDX_W), .DP_W(DP_W), .RB_AW(RB_AW),
    .RB_DW(RB_DW), .GADDR_W(GADDR_W), .DP_OFS(DP_OFS), .PIDX_OFS(PIDX_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_wr      (rb_wr),
    .rb_addr    (rb_addr),
    .rb_wdata   (rb_wdata),
    .rb_rdata   (rb_rdata),
    .core_ld    (core_ld),
    .core_pidx  (core_pidx),
    .acc_direct (acc_direct),
    .loc_addr   (loc_addr),
    .glb_addr   (glb_addr),
    .region     (region),
    .pidx_q     (pidx_q),
    .dp_q       (dp_q),
    .dp_lock    (dp_lock)
);

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rb_wr = 1'b0;
    logic [7:0]  rb_addr = '0;
    logic [7:0]  rb_wdata = '0;
    logic [7:0]  rb_rdata;
    logic        core_ld = 1'b0;
    logic [3:0]  core_pidx = '0;
    logic        acc_direct = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_ofs = '0;
    logic [15:0] loc_addr;
    logic [17:0] glb_addr;
    logic [1:0]  region;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [3:0] m_pidx;
    logic [7:0] m_dp;
    bit         m_lock;

    page_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .rb_wr(rb_wr), .rb_addr(rb_addr),
        .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .core_ld(core_ld),
        .core_pidx(core_pidx), .acc_direct(acc_direct), .acc_addr(acc_addr),
        .acc_ofs(acc_ofs), .loc_addr(loc_addr), .glb_addr(glb_addr),
        .region(region)
    );

    always #10 clk = ~clk;

    // Expected {region, glb, loc} from the requirements.
    function automatic logic [35:0] exp_map(input bit dir, input logic [15:0] a,
                                            input logic [7:0] o, input logic [3:0] p,
                                            input logic [7:0] d);
        logic [15:0] l;
        l = dir ? {d, o} : a;
        if (l[15:14] == 2'b10)
            return {2'b10, p, l[13:0], l};
        else
            return {(dir ? 2'b01 : 2'b00), 2'b00, l, l};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] off);
        if (off == 8'h31) return {4'h0, m_pidx};
        if (off == 8'h30) return m_dp;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, update model at the edge.
    task automatic step(input bit wr, input logic [7:0] ad, input logic [7:0] wd,
                        input bit ld, input logic [3:0] cp, input bit dir,
                        input logic [15:0] a, input logic [7:0] o, input string req);
        logic [35:0] e;
        @(negedge clk);
        rb_wr = wr; rb_addr = ad; rb_wdata = wd; core_ld = ld; core_pidx = cp;
        acc_direct = dir; acc_addr = a; acc_ofs = o;
        #2;
        e = exp_map(dir, a, o, m_pidx, m_dp);
        chk(req, {46'd0, region, glb_addr}, {46'd0, e[35:16]});
        chk(req, {48'd0, loc_addr}, {48'd0, e[15:0]});
        chk(req, {56'd0, rb_rdata}, {56'd0, exp_rd(ad)});
        @(posedge clk);
        if (ld) m_pidx = cp;
        else if (wr && ad == 8'h31) m_pidx = wd[3:0];
        if (wr && ad == 8'h30 && !m_lock) begin m_dp = wd; m_lock = 1'b1; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rb_wr = 1'b0; core_ld = 1'b0;
        repeat (2) @(posedge clk);
        m_pidx = 4'hE; m_dp = 8'h00; m_lock = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        do_reset();
        // R1 reset values read back
        step(0, 8'h31, 0, 0, 0, 0, 16'h0000, 0, "R1");
        step(0, 8'h30, 0, 0, 0, 0, 16'h0000, 0, "R1");
        // R7 window with reset page 0xE
        step(0, 8'h00, 0, 0, 0, 0, 16'h8000, 0, "R7");
        step(0, 8'h00, 0, 0, 0, 0, 16'hBFFF, 0, "R7");
        // R9 edges of the window
        step(0, 8'h00, 0, 0, 0, 0, 16'h7FFF, 0, "R9");
        step(0, 8'h00, 0, 0, 0, 0, 16'hC000, 0, "R9");
        // R2 bus write then R10 effective next cycle
        step(1, 8'h31, 8'hF3, 0, 0, 0, 16'h9234, 0, "R2");
        step(0, 8'h31, 0, 0, 0, 0, 16'h9234, 0, "R10");
        // R5 core load
        step(0, 8'h00, 0, 1, 4'h7, 0, 16'hA001, 0, "R5");
        step(0, 8'h31, 0, 0, 0, 0, 16'hA001, 0, "R5");
        // R6 collision
        step(1, 8'h31, 8'h05, 1, 4'hC, 0, 16'h8000, 0, "R6");
        step(0, 8'h31, 0, 0, 0, 0, 16'h8000, 0, "R6");
        // R11 unmapped write and read
        step(1, 8'h32, 8'hFF, 0, 0, 0, 16'h0000, 0, "R11");
        step(0, 8'h32, 0, 0, 0, 0, 16'h0000, 0, "R11");
        step(0, 8'h31, 0, 0, 0, 0, 16'h0000, 0, "R11");
        // R8 direct outside window, before write (dp 0)
        step(0, 8'h30, 0, 0, 0, 1, 16'hFFFF, 8'h44, "R8");
        // R3 first write 0x80, direct falls into window
        step(1, 8'h30, 8'h80, 0, 0, 1, 16'h0000, 8'h12, "R3");
        step(0, 8'h30, 0, 0, 0, 1, 16'h0000, 8'h12, "R8");
        // R4 second write ignored
        step(1, 8'h30, 8'h21, 0, 0, 0, 16'h0000, 0, "R4");
        step(0, 8'h30, 0, 0, 0, 1, 16'h0000, 8'hEE, "R4");
        // R4 reset re-arms
        do_reset();
        step(0, 8'h30, 0, 0, 0, 0, 16'h0000, 0, "R1");
        step(1, 8'h30, 8'h21, 0, 0, 1, 16'h0000, 8'h01, "R4");
        step(0, 8'h30, 0, 0, 0, 1, 16'h0000, 8'h01, "R8");
        // Random mix, with occasional reset
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ad;
            logic [1:0] sel;
            sel = 2'($urandom_range(0, 3));
            ad = (sel == 0) ? 8'h30 : (sel == 1) ? 8'h31 : 8'($urandom);
            if (($urandom % 400) == 0) do_reset();
            step(bit'($urandom % 2), ad, 8'($urandom), bit'(($urandom % 4) == 0),
                 4'($urandom), bit'($urandom % 2), 16'($urandom), 8'($urandom), "R10");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule